// File: doc/BRIEF.md
# Boundary-Scan Data Register with Output-Enable Cells

This block is the boundary-scan data register of a small device that has a group of system inputs and two groups of outputs, called the A side and the B side. Each group of outputs has its own active-high output enable. The cells sit in one serial chain between `tdi` and `tdo`. Each input pin has an observe-only cell. Each output pin has a controlling cell, and so does each of the two enable signals. A controlling cell has a shift stage, an update latch and a multiplexer.

An external TAP controller drives the capture, shift and update strobes. An instruction decoder drives `test_mode` and `bypass_sel`. When `test_mode` is high, the update latches drive the outputs and enables. When it is low, core data and core enables pass straight through. A one-bit bypass stage sits next to the chain. It loads 0 on capture and is placed on `tdo` when `bypass_sel` is high. Test-logic reset clears every latch, so test mode can never turn on an output with stale data.

Top module: `bscan_chain`

## Requirements
- R1: Chain position 0 is nearest `tdo`. Positions 0..N_IN-1 hold `pin_in[0..N_IN-1]`. Position N_IN holds the A-enable cell. The next N_A positions hold `pin_a[0..]`. Then comes the B-enable cell, followed by N_B positions for `pin_b[0..]`. The chain length is N_IN+N_A+N_B+2.
- R2: On a rising `tck` with `capture_dr` high, input cells load `pin_in`, data cells load `core_a`/`core_b`, and the enable cells load `core_oe_a`/`core_oe_b`.
- R3: On a rising `tck` with `shift_dr` high and `capture_dr` low, every stage takes the value of its neighbour farther from `tdo`, and `tdi` enters the far end. With `bypass_sel` low, `tdo` is the value of position 0.
- R4: Update latches load from their shift stages on a falling `tck` while `update_dr` is high. At all other times they hold, whatever capture or shift does.
- R5: With `test_mode` low, `pin_a`, `pin_b`, `oe_a` and `oe_b` equal `core_a`, `core_b`, `core_oe_a` and `core_oe_b`.
- R6: With `test_mode` high, the outputs show the update latches. A latched 1 in an enable cell drives its enable high.
- R7: Input cells have no latch. A value shifted into positions 0..N_IN-1 and then updated changes no output.
- R8: While `trst_n` is low, every latch and stage is cleared, so in test mode `oe_a` and `oe_b` read 0.
- R9: The bypass stage loads 0 on capture and `tdi` on shift. `tdo` shows it while `bypass_sel` is high, giving a one-cycle delay from `tdi`.
- R10: When `capture_dr` and `shift_dr` are both high, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe, acted on at falling tck |
| bypass_sel | input | 1 | Route bypass stage to tdo |
| test_mode | input | 1 | Outputs driven from update latches |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| pin_in | input | N_IN | System input pins (observed) |
| core_a | input | N_A | Core data for A side |
| core_oe_a | input | 1 | Core enable for A side |
| core_b | input | N_B | Core data for B side |
| core_oe_b | input | 1 | Core enable for B side |
| pin_a | output | N_A | A-side output pins |
| oe_a | output | 1 | A-side output enable, active high |
| pin_b | output | N_B | B-side output pins |
| oe_b | output | 1 | B-side output enable, active high |

## Verification
A wrong shift stage shows on `tdo` in the shift cycle where its bit reaches position 0, which is at most one chain length of cycles later. A wrong update latch shows on the pins as soon as `test_mode` is high, in the half cycle after the falling edge that loads it. A latch that fails to hold, or an input cell that wrongly feeds an output, shows on the pins at once. The order of the cells can only be seen in serial unload order, so each unload compares every bit position.

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN = 4,
  parameter int N_A  = 4,
  parameter int N_B  = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            bypass_sel,
  input  logic            test_mode,
  input  logic            tdi,
  output logic            tdo,
  input  logic [N_IN-1:0] pin_in,
  input  logic [N_A-1:0]  core_a,
  input  logic            core_oe_a,
  input  logic [N_B-1:0]  core_b,
  input  logic            core_oe_b,
  output logic [N_A-1:0]  pin_a,
  output logic            oe_a,
  output logic [N_B-1:0]  pin_b,
  output logic            oe_b
);
  localparam int LEN  = N_IN + N_A + N_B + 2;
  localparam int NCTL = LEN - N_IN;
  localparam int U_A  = 1;
  localparam int U_OEB = N_A + 1;
  localparam int U_B  = N_A + 2;

  logic [LEN-1:0]  sr;
  logic [LEN-1:0]  cap;
  logic [NCTL-1:0] upd;
  logic            byp;

  // chain order from tdo: inputs, A enable, A data, B enable, B data
  assign cap = {core_b, core_oe_b, core_a, core_oe_a, pin_in};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)         sr <= '0;
    else if (capture_dr) sr <= cap;
    else if (shift_dr)   sr <= {tdi, sr[LEN-1:1]};

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)         byp <= 1'b0;
    else if (capture_dr) byp <= 1'b0;
    else if (shift_dr)   byp <= tdi;

  // only controlling cells own a latch
  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)        upd <= '0;
    else if (update_dr) upd <= sr[LEN-1:N_IN];

  assign tdo   = bypass_sel ? byp : sr[0];
  assign oe_a  = test_mode ? upd[0]         : core_oe_a;
  assign pin_a = test_mode ? upd[U_A +: N_A] : core_a;
  assign oe_b  = test_mode ? upd[U_OEB]     : core_oe_b;
  assign pin_b = test_mode ? upd[U_B +: N_B] : core_b;
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_A = 4,
  parameter int N_B = 4
) (
  input logic           tck,
  input logic           trst_n,
  input logic           capture_dr,
  input logic           shift_dr,
  input logic           update_dr,
  input logic           bypass_sel,
  input logic           test_mode,
  input logic           tdi,
  input logic           tdo,
  input logic [N_A-1:0] core_a,
  input logic           core_oe_a,
  input logic [N_B-1:0] core_b,
  input logic           core_oe_b,
  input logic [N_A-1:0] pin_a,
  input logic           oe_a,
  input logic [N_B-1:0] pin_b,
  input logic           oe_b
);
  AST_CORE_PASS: assert property (@(posedge tck) disable iff (!trst_n)
    !test_mode |-> (pin_a == core_a && pin_b == core_b && oe_a == core_oe_a && oe_b == core_oe_b)); // R5

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (test_mode && $past(test_mode) && $past(trst_n) && !update_dr) |->
      ($stable(pin_a) && $stable(pin_b) && $stable(oe_a) && $stable(oe_b))); // R4

  AST_RESET_OFF: assert property (@(posedge tck) disable iff (!trst_n)
    ($rose(trst_n) && test_mode) |-> (!oe_a && !oe_b)); // R8

  AST_BYP_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(trst_n) && $past(shift_dr) && !$past(capture_dr) && $past(bypass_sel) && bypass_sel)
      |-> tdo == $past(tdi)); // R9

  AST_BYP_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
    ($past(trst_n) && $past(capture_dr) && bypass_sel) |-> !tdo); // R9
endmodule

bind bscan_chain bscan_chain_chk #(.N_A(N_A), .N_B(N_B)) u_chk (
  .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .update_dr(update_dr), .bypass_sel(bypass_sel), .test_mode(test_mode),
  .tdi(tdi), .tdo(tdo), .core_a(core_a), .core_oe_a(core_oe_a),
  .core_b(core_b), .core_oe_b(core_oe_b), .pin_a(pin_a), .oe_a(oe_a),
  .pin_b(pin_b), .oe_b(oe_b));

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int NI = 4, NA = 4, NB = 4;
  localparam int L = NI + NA + NB + 2;

  logic tck = 0, trst_n = 0, capture_dr = 0, shift_dr = 0, update_dr = 0;
  logic bypass_sel = 0, test_mode = 0, tdi = 0, tdo;
  logic [NI-1:0] pin_in = '0;
  logic [NA-1:0] core_a = '0, pin_a;
  logic [NB-1:0] core_b = '0, pin_b;
  logic core_oe_a = 0, core_oe_b = 0, oe_a, oe_b;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  bscan_chain #(.N_IN(NI), .N_A(NA), .N_B(NB)) u_bscan_chain (.*);

  // stimulus: {pin_in, core_a, core_b, core_oe_a, core_oe_b}
  localparam logic [13:0] VEC [6] = '{
    14'b0000_0000_0000_0_0, 14'b1111_1111_1111_1_1, 14'b1010_0101_1100_1_0,
    14'b0001_1000_0011_0_1, 14'b0110_1001_0110_1_1, 14'b1000_0001_1110_0_0};

  function automatic logic [L-1:0] chain_of(logic [13:0] v);
    return {v[5:2], v[0], v[9:6], v[1], v[13:10]};
  endfunction

  task automatic tick(); @(posedge tck); #1; endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin bad++; $display("FAIL %s act=%h exp=%h", r, act, exp); end
  endtask

  task automatic scan(input logic [L-1:0] din, output logic [L-1:0] dout);
    shift_dr = 1;
    for (int i = 0; i < L; i++) begin dout[i] = tdo; tdi = din[i]; tick(); end
    shift_dr = 0; tdi = 0;
  endtask

  task automatic capture(); capture_dr = 1; tick(); capture_dr = 0; endtask
  task automatic update();  update_dr = 1;  tick(); update_dr = 0;  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [L-1:0] got, p, q;
    test_mode = 1;
    tick(); tick();
    chk("R8 reset oe", {30'd0, oe_a, oe_b}, 32'd0);
    chk("R8 reset pins", {24'd0, pin_a, pin_b}, 32'd0);
    trst_n = 1; test_mode = 0; tick();

    // R1 R2 R3: capture each vector and unload it
    for (int k = 0; k < 6; k++) begin
      {pin_in, core_a, core_b, core_oe_a, core_oe_b} = VEC[k];
      capture();
      scan('0, got);
      chk("R1 R2 capture order", {18'd0, got}, {18'd0, chain_of(VEC[k])});
    end

    // R3: shift-through
    p = {4'b1001, 1'b0, 4'b0110, 1'b1, 4'b1010};
    scan(p, got);
    scan('0, got);
    chk("R3 shift through", {18'd0, got}, {18'd0, p});

    // R5, R6: preload and update
    core_a = 4'b0011; core_b = 4'b1100; core_oe_a = 0; core_oe_b = 1;
    scan(p, got);
    update();
    chk("R5 pass A", {27'd0, oe_a, pin_a}, {27'd0, 1'b0, 4'b0011});
    chk("R5 pass B", {27'd0, oe_b, pin_b}, {27'd0, 1'b1, 4'b1100});
    test_mode = 1; #1;
    chk("R6 latched A", {27'd0, oe_a, pin_a}, {27'd0, 1'b1, 4'b0110});
    chk("R6 latched B", {27'd0, oe_b, pin_b}, {27'd0, 1'b0, 4'b1001});

    // R4: shift and capture without update leave outputs alone
    q = {4'b0101, 1'b1, 4'b1111, 1'b0, 4'b0000};
    scan(q, got);
    capture();
    chk("R4 hold A", {27'd0, oe_a, pin_a}, {27'd0, 1'b1, 4'b0110});
    chk("R4 hold B", {27'd0, oe_b, pin_b}, {27'd0, 1'b0, 4'b1001});
    scan(q, got);
    update();
    chk("R4 update A", {27'd0, oe_a, pin_a}, {27'd0, 1'b0, 4'b1111});
    chk("R4 update B", {27'd0, oe_b, pin_b}, {27'd0, 1'b1, 4'b0101});

    // R7: only input-cell bits differ; outputs unchanged
    scan({q[L-1:NI], ~q[NI-1:0]}, got);
    update();
    chk("R7 input bits A", {27'd0, oe_a, pin_a}, {27'd0, 1'b0, 4'b1111});
    chk("R7 input bits B", {27'd0, oe_b, pin_b}, {27'd0, 1'b1, 4'b0101});

    // R10: capture wins over shift
    {pin_in, core_a, core_b, core_oe_a, core_oe_b} = VEC[2];
    capture_dr = 1; shift_dr = 1; tdi = 1; tick();
    capture_dr = 0; shift_dr = 0; tdi = 0;
    scan('0, got);
    chk("R10 capture priority", {18'd0, got}, {18'd0, chain_of(VEC[2])});

    // R8: mid-run reset with both enables latched on
    scan({4'b1111, 1'b1, 4'b1111, 1'b1, 4'b0000}, got);
    update();
    chk("R6 both enabled", {30'd0, oe_a, oe_b}, 32'd3);
    trst_n = 0; tick(); tick();
    chk("R8 mid reset", {22'd0, oe_a, oe_b, pin_a, pin_b}, 32'd0);
    trst_n = 1; tick();

    // R9: bypass stage
    bypass_sel = 1;
    shift_dr = 1; tdi = 1; tick(); shift_dr = 0; tdi = 0;
    chk("R9 bypass shift 1", {31'd0, tdo}, 32'd1);
    capture();
    chk("R9 bypass capture", {31'd0, tdo}, 32'd0);
    shift_dr = 1; tdi = 1; tick();
    chk("R9 bypass delay 1", {31'd0, tdo}, 32'd1);
    tdi = 0; tick();
    chk("R9 bypass delay 0", {31'd0, tdo}, 32'd0);
    shift_dr = 0; bypass_sel = 0;
    tick();
    finish_up();
  end
endmodule